// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block owns the program counter of a simple processor whose instructions are all 32 bits long. On every clock edge where it is enabled, it loads a new PC. The new value is chosen from the instruction currently presented, and the choice is made among four flow kinds. SEQ goes on to the next word. BEQ and BNE are conditional branches that compare two register operands. JMP is an unconditional jump.

Branches take a word-scaled, sign-extended offset and add it to the incremented PC. Jumps keep the top bits of the incremented PC and replace the rest with the instruction's 26-bit target field, shifted left by two. The incremented PC, the selected next PC and a redirect flag are combinational outputs, so a fetch stage can use them in the same cycle.

The decode step maps the opcode to one of the four kinds. That step acts as the state of the selection logic. Each kind has one transition into the PC register: the edge where enable is high.

Top module: `nxpc_unit`

## Requirements
- R1: When `rst` is high at a rising edge, `pc` becomes 32'h0000_0000, whatever the value of `en`.
- R2: When `rst` is low and `en` is low at a rising edge, `pc` keeps its value.
- R3: When `rst` is low and `en` is high at a rising edge, `pc` takes the value that `pc_next` showed just before that edge.
- R4: `pc_inc` always equals `pc + 4` modulo 2^32, so 32'hFFFF_FFFC gives 0.
- R5: With opcode `insn[31:26] == 6'h04` (BEQ), `taken` is 1 exactly when `opnd_a == opnd_b`. When taken, `pc_next` is `pc_inc + (sign_extend(insn[15:0]) << 2)`. Otherwise it is `pc_inc`.
- R6: With opcode `6'h05` (BNE), `taken` is 1 exactly when `opnd_a != opnd_b`. The target has the same form as in R5, and `pc_next` is `pc_inc` when not taken.
- R7: With opcode `6'h02` (JMP), `taken` is 1 and `pc_next` is `{pc_inc[31:28], insn[25:0], 2'b00}`. The top four bits come from the incremented PC, not from `pc`.
- R8: Any other opcode gives `taken == 0` and `pc_next == pc_inc`, whatever the operands and the other instruction bits are.
- R9: Branch arithmetic wraps modulo 2^32 with no alignment check. A negative offset moves backward, and a target below 0 or above 32'hFFFF_FFFF wraps around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; low holds the PC |
| insn | input | 32 | Instruction word at the current PC |
| opnd_a | input | 32 | First compare operand |
| opnd_b | input | 32 | Second compare operand |
| pc | output | 32 | Current program counter |
| pc_inc | output | 32 | Current PC plus 4 |
| pc_next | output | 32 | Value the PC loads at the next enabled edge |
| taken | output | 1 | High when a branch is taken or a jump is decoded |

## Verification
The embedded assertions take for granted that `insn`, `opnd_a`, `opnd_b` and `en` are stable around the clock edge. They also assume that at least one reset cycle comes before anything else is checked. The bench meets this by driving every input on the falling edge and sampling outputs before the next rising edge. It also opens the run with a reset.

Random opcodes favour the three control-flow codes. The equal-operand case is forced half the time, so that both outcomes of each branch occur often. Directed steps then walk the PC through a wrap to zero, a backward branch and a jump made where the incremented PC has already wrapped.

// File: rtl/pcnu_pkg.sv
package pcnu_pkg;

    // Flow kind selected by the opcode decode
    typedef enum logic [1:0] {
        FLOW_SEQ = 2'd0,
        FLOW_BEQ = 2'd1,
        FLOW_BNE = 2'd2,
        FLOW_JMP = 2'd3
    } flow_e;

    localparam int unsigned OP_W_DEF    = 6;
    localparam logic [5:0]  OPC_JMP_DEF = 6'h02;
    localparam logic [5:0]  OPC_BEQ_DEF = 6'h04;
    localparam logic [5:0]  OPC_BNE_DEF = 6'h05;

endpackage

// File: rtl/pcnu_decode.sv
module pcnu_decode
    import pcnu_pkg::*;
#(
    parameter int unsigned  INSN_W  = 32,
    parameter int unsigned  OP_W    = OP_W_DEF,
    parameter int unsigned  IMM_W   = 16,
    parameter int unsigned  JADDR_W = 26,
    parameter logic [OP_W-1:0] OPC_JMP = OPC_JMP_DEF,
    parameter logic [OP_W-1:0] OPC_BEQ = OPC_BEQ_DEF,
    parameter logic [OP_W-1:0] OPC_BNE = OPC_BNE_DEF
) (
    input  logic [INSN_W-1:0]  insn,
    output flow_e              kind,
    output logic [IMM_W-1:0]   offset,
    output logic [JADDR_W-1:0] jfield
);

    logic [OP_W-1:0] opcode;

    assign opcode = insn[INSN_W-1 -: OP_W];
    assign offset = insn[IMM_W-1:0];
    assign jfield = insn[JADDR_W-1:0];

    always_comb begin
        unique case (opcode)
            OPC_BEQ: kind = FLOW_BEQ;
            OPC_BNE: kind = FLOW_BNE;
            OPC_JMP: kind = FLOW_JMP;
            default: kind = FLOW_SEQ;
        endcase
    end

endmodule

// File: rtl/pcnu_target.sv
module pcnu_target #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned IMM_W   = 16,
    parameter int unsigned JADDR_W = 26,
    parameter int unsigned ALIGN_W = 2
) (
    input  logic [ADDR_W-1:0]  pc,
    input  logic [IMM_W-1:0]   offset,
    input  logic [JADDR_W-1:0] jfield,
    output logic [ADDR_W-1:0]  pc_inc,
    output logic [ADDR_W-1:0]  br_tgt,
    output logic [ADDR_W-1:0]  jmp_tgt
);

    localparam int unsigned SEXT_W   = ADDR_W - IMM_W - ALIGN_W;
    localparam int unsigned REGION_W = ADDR_W - JADDR_W - ALIGN_W;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << ALIGN_W;

    logic [ADDR_W-1:0] disp;

    assign pc_inc = pc + STEP;
    assign disp   = {{SEXT_W{offset[IMM_W-1]}}, offset, {ALIGN_W{1'b0}}};
    assign br_tgt = pc_inc + disp;

    generate
        if (REGION_W > 0) begin : g_region
            assign jmp_tgt = {pc_inc[ADDR_W-1 -: REGION_W], jfield, {ALIGN_W{1'b0}}};
        end else begin : g_flat
            assign jmp_tgt = {jfield[ADDR_W-ALIGN_W-1:0], {ALIGN_W{1'b0}}};
        end
    endgenerate

endmodule

// File: rtl/nxpc_unit.sv
module nxpc_unit
    import pcnu_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned OP_W    = OP_W_DEF,
    parameter int unsigned IMM_W   = 16,
    parameter int unsigned JADDR_W = 26,
    parameter int unsigned ALIGN_W = 2,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [ADDR_W-1:0] insn,
    input  logic [ADDR_W-1:0] opnd_a,
    input  logic [ADDR_W-1:0] opnd_b,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] pc_inc,
    output logic [ADDR_W-1:0] pc_next,
    output logic              taken
);

    localparam int unsigned REGION_W = ADDR_W - JADDR_W - ALIGN_W;

    flow_e              kind;
    logic [IMM_W-1:0]   offset;
    logic [JADDR_W-1:0] jfield;
    logic [ADDR_W-1:0]  br_tgt;
    logic [ADDR_W-1:0]  jmp_tgt;
    logic               same;
    logic [ADDR_W-1:0]  pc_q;

    pcnu_decode #(
        .INSN_W  (ADDR_W),
        .OP_W    (OP_W),
        .IMM_W   (IMM_W),
        .JADDR_W (JADDR_W)
    ) u_dec (
        .insn   (insn),
        .kind   (kind),
        .offset (offset),
        .jfield (jfield)
    );

    pcnu_target #(
        .ADDR_W  (ADDR_W),
        .IMM_W   (IMM_W),
        .JADDR_W (JADDR_W),
        .ALIGN_W (ALIGN_W)
    ) u_tgt (
        .pc      (pc_q),
        .offset  (offset),
        .jfield  (jfield),
        .pc_inc  (pc_inc),
        .br_tgt  (br_tgt),
        .jmp_tgt (jmp_tgt)
    );

    assign same = (opnd_a == opnd_b);

    // Output process: next-address selection per flow kind
    always_comb begin
        unique case (kind)
            FLOW_BEQ: begin
                taken   = same;
                pc_next = same ? br_tgt : pc_inc;
            end
            FLOW_BNE: begin
                taken   = !same;
                pc_next = same ? pc_inc : br_tgt;
            end
            FLOW_JMP: begin
                taken   = 1'b1;
                pc_next = jmp_tgt;
            end
            default: begin
                taken   = 1'b0;
                pc_next = pc_inc;
            end
        endcase
    end

    // State process: the program counter register
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= RESET_PC;
        end else if (en) begin
            pc_q <= pc_next;
        end
    end

    assign pc = pc_q;

    // Becomes 1 once a reset edge has been seen
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b1;
        end
    end

    AST_RESET_LOADS_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc == RESET_PC)); // R1

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(rst) && !$past(en)) |-> (pc == $past(pc))); // R2

    AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(rst) && $past(en) && !$past(taken))
            |-> (pc == $past(pc) + (ADDR_W'(1) << ALIGN_W))); // R3

    AST_NO_TAKE_SEQ: assert property (@(posedge clk) disable iff (rst)
        (armed && !taken) |-> (pc_next == pc_inc)); // R8

    AST_BRANCH_OPERANDS: assert property (@(posedge clk) disable iff (rst)
        (armed && kind == FLOW_BEQ && taken) |-> (opnd_a == opnd_b)); // R5

    AST_JUMP_REGION: assert property (@(posedge clk) disable iff (rst)
        (armed && kind == FLOW_JMP)
            |-> (taken && pc_next[ADDR_W-1 -: REGION_W] == pc_inc[ADDR_W-1 -: REGION_W])); // R7

endmodule

// File: tb/nxpc_unit_bench.sv
module nxpc_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [31:0] insn = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] pc, pc_inc, pc_next;
    logic        taken;

    int unsigned n_checks = 0;
    int unsigned n_errors = 0;
    int unsigned cycles = 0;
    logic [31:0] m_pc = '0;

    always #10 clk = ~clk;   // 50 MHz

    nxpc_unit u_nxpc_unit (
        .clk(clk), .rst(rst), .en(en), .insn(insn),
        .opnd_a(opnd_a), .opnd_b(opnd_b),
        .pc(pc), .pc_inc(pc_inc), .pc_next(pc_next), .taken(taken)
    );

    function automatic logic exp_taken(logic [31:0] i, logic [31:0] a, logic [31:0] b);
        case (i[31:26])
            6'h04:   return a == b;
            6'h05:   return a != b;
            6'h02:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] exp_next(logic [31:0] p, logic [31:0] i,
                                             logic [31:0] a, logic [31:0] b);
        logic [31:0] inc;
        logic signed [31:0] off;
        inc = p + 32'd4;
        off = 32'(signed'(i[15:0])) * 4;
        if (!exp_taken(i, a, b)) return inc;
        if (i[31:26] == 6'h02) return {inc[31:28], i[25:0], 2'b00};
        return inc + 32'(off);
    endfunction

    function automatic string tag_of(logic [31:0] i);
        case (i[31:26])
            6'h04:   return "R5";
            6'h05:   return "R6";
            6'h02:   return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Drive on the falling edge, check before the rising edge, then update the model
    task automatic step(logic [31:0] i, logic [31:0] a, logic [31:0] b,
                        logic e, string ntag);
        string t;
        @(negedge clk);
        insn = i; opnd_a = a; opnd_b = b; en = e; rst = 1'b0;
        #2;
        t = (ntag == "") ? tag_of(i) : ntag;
        chk("R4", "pc_inc", pc_inc, m_pc + 32'd4);
        chk(t, "pc_next", pc_next, exp_next(m_pc, i, a, b));
        chk(t, "taken", {31'd0, taken}, {31'd0, exp_taken(i, a, b)});
        @(posedge clk);
        #2;
        if (e) begin
            m_pc = exp_next(m_pc, i, a, b);
            chk("R3", "pc after enabled edge", pc, m_pc);
        end else begin
            chk("R2", "pc held while disabled", pc, m_pc);
        end
    endtask

    task automatic do_reset(logic e);
        @(negedge clk);
        rst = 1'b1; en = e;
        insn = {6'h02, 26'h3ABCDEF};
        @(posedge clk);
        #2;
        m_pc = '0;
        chk("R1", "pc after reset", pc, 32'h0);
        chk("R1", "pc_inc after reset", pc_inc, 32'h4);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                n_checks++;
                n_errors++;
                $display("FAIL watchdog expired: actual=%0d expected<=200000", cycles);
                $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
                $finish;
            end
        end
    end

    initial begin : main
        logic [31:0] a, b, i;
        logic [5:0]  op;
        void'($urandom(32'd20240611));

        do_reset(1'b1);

        // R9: backward branch from 0 with offset -1 lands back on 0
        step({6'h04, 5'd1, 5'd2, 16'hFFFF}, 32'h55, 32'h55, 1'b1, "R9");
        chk("R9", "backward branch to zero", pc, 32'h0);
        // R9: most negative offset wraps below zero
        step({6'h05, 5'd1, 5'd2, 16'h8000}, 32'h1, 32'h2, 1'b1, "R9");
        chk("R9", "wrap below zero", pc, 32'hFFFE_0004);
        // R7: jump keeps region 4'hF
        step({6'h02, 26'h3FF_FFFF}, 32'h0, 32'h0, 1'b1, "R7");
        chk("R7", "jump to top word", pc, 32'hFFFF_FFFC);
        // R4 wrap, R7 region taken from the wrapped incremented PC
        step({6'h02, 26'h000_0010}, 32'h0, 32'h0, 1'b1, "R7");
        chk("R7", "jump region from pc_inc", pc, 32'h0000_0040);
        // R8: unknown opcode with equal operands is not taken
        step({6'h06, 26'h3FF_FFFF}, 32'h7, 32'h7, 1'b1, "R8");
        // R2: a taken jump does nothing while disabled
        step({6'h02, 26'h123_4567}, 32'h0, 32'h0, 1'b0, "R2");
        // R5 / R6 not taken
        step({6'h04, 10'd0, 16'h0100}, 32'h1, 32'h2, 1'b1, "R5");
        step({6'h05, 10'd0, 16'h0100}, 32'h9, 32'h9, 1'b1, "R6");
        // R1: reset wins over disable
        do_reset(1'b0);

        for (int k = 0; k < 3000; k++) begin
            case ($urandom % 8)
                0, 1:    op = 6'h04;
                2, 3:    op = 6'h05;
                4:       op = 6'h02;
                default: op = 6'($urandom);
            endcase
            i = {op, 26'($urandom)};
            if ($urandom % 3 == 0) i[15:0] = 16'($urandom % 16) - 16'd8;
            a = $urandom;
            b = ($urandom % 2 == 0) ? a : $urandom;
            step(i, a, b, ($urandom % 5) != 0, "");
            if (k % 997 == 996) do_reset($urandom % 2 == 0);
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule